// File: doc/BRIEF.md
# Two-of-Four Sparse Weight Packer

This block takes a stream of dense weights, one group of four 16-bit floating-point lanes per beat, and reduces each group to exactly two stored values. Each stored value comes with a 2-bit lane number. A sparse matrix unit that receives only these two products per group does half the multiply work of the dense group, so it can double its effective rate. Groups that already hold two or fewer non-zero weights pass through losslessly. Groups holding three or four non-zero weights are flagged, and the two weights with the largest magnitude are kept, so the stream never stalls on bad data.

The packing path has valid/ready handshakes on both sides and one register stage, so it accepts one group per cycle while the consumer keeps up. A separate combinational unpacker takes two values and two lane numbers and rebuilds the dense group. A packed group can therefore be checked by a round trip, or used by logic that needs dense operands again.

Top module: `sp24_codec`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A group transfers when `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_vals`, `out_idx` and `out_viol` hold their values.
- R2: A lane counts as zero when its low 15 bits (exponent and mantissa) are all zero, whatever its sign bit. Every zero that the packer emits is the word 0x0000.
- R3: Lane k of `in_group` is bits [16k+15:16k]. Slot s of `out_vals` is bits [16s+15:16s] and its lane number is `out_idx[2s+1:2s]`. The lane number of slot 0 is always strictly less than that of slot 1.
- R4: A group with exactly two non-zero lanes emits those two values unchanged, in lane order, with their lane numbers, and `out_viol` = 0.
- R5: A group with one non-zero lane k emits slot lane numbers (0,1) with values (v,0x0000) when k = 0. Otherwise it emits lane numbers (0,k) with values (0x0000,v). `out_viol` = 0.
- R6: A group with no non-zero lane emits lane numbers (0,1), both values 0x0000, and `out_viol` = 0.
- R7: A group with three or four non-zero lanes sets `out_viol` = 1. It keeps the two lanes whose low 15 bits are largest as unsigned numbers. On equal magnitudes the lower lane wins. The kept lanes are emitted in lane order.
- R8: `exp_group` places each `exp_vals` slot in the lane named by its `exp_idx` field and puts 0x0000 in the other two lanes. Repacking and unpacking a group with at most two non-zero lanes, whose zero lanes are 0x0000, returns the group bit for bit.
- R9: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R10: A group accepted at a clock edge is on the output from that edge on. With `out_ready` held high, a new group is accepted in the same cycle the previous one leaves, so the block sustains one group per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Dense group present |
| in_ready | output | 1 | Packer can take a group |
| in_group | input | 64 | Four 16-bit lanes, lane 0 in the low bits |
| out_valid | output | 1 | Packed group present |
| out_ready | input | 1 | Consumer takes the packed group |
| out_vals | output | 32 | Two kept values, slot 0 in the low bits |
| out_idx | output | 4 | Two 2-bit lane numbers, slot 0 in the low bits |
| out_viol | output | 1 | Group had more than two non-zero lanes |
| exp_vals | input | 32 | Two values to unpack |
| exp_idx | input | 4 | Their lane numbers |
| exp_group | output | 64 | Rebuilt dense group |

## Verification
Two things can happen in one cycle: a packed group leaves through `out_ready`, and a new dense group enters through `in_valid`. The bench holds `out_ready` high through back-to-back directed groups, then toggles it randomly while it keeps offering groups. This makes the cycles where a drain and a refill coincide frequent, alongside pure stalls. A behavioural queue model pushes on every input transfer and pops on every output transfer. Every cycle, the output register is compared with the head of the queue, so a lost, duplicated or reordered group shows up as a value mismatch or as a wrong `out_valid`. The unpacker sees each packed result in the same cycle and is checked against a lane placement computed in the bench, and against the original group when the round trip must be exact.

// File: rtl/sp24_pkg.sv
package sp24_pkg;

  localparam int unsigned SP_DATA_W = 16;
  localparam int unsigned SP_LANES  = 4;
  localparam int unsigned SP_KEEP   = 2;

  // Occupancy class of a dense group, brought out for checking.
  typedef enum logic [1:0] {
    CLS_EMPTY   = 2'd0,
    CLS_PARTIAL = 2'd1,
    CLS_FULL    = 2'd2,
    CLS_OVER    = 2'd3
  } sp24_class_e;

  function automatic sp24_class_e classify(input int unsigned nz_cnt,
                                           input int unsigned keep);
    if (nz_cnt == 0)         return CLS_EMPTY;
    else if (nz_cnt < keep)  return CLS_PARTIAL;
    else if (nz_cnt == keep) return CLS_FULL;
    else                     return CLS_OVER;
  endfunction

endpackage

// File: rtl/sp24_zero_detect.sv
module sp24_zero_detect #(
  parameter int unsigned DATA_W = sp24_pkg::SP_DATA_W,
  parameter int unsigned LANES  = sp24_pkg::SP_LANES
) (
  input  logic [LANES*DATA_W-1:0] group_i,
  output logic [LANES-1:0]        nz_o
);
  localparam int unsigned MAG_W = DATA_W - 1;

  // A lane is zero when exponent and mantissa are clear; sign is ignored.
  function automatic logic lane_nonzero(input logic [DATA_W-1:0] w);
    return (w[MAG_W-1:0] != '0);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign nz_o[l] = lane_nonzero(group_i[l*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/sp24_select.sv
module sp24_select
  import sp24_pkg::*;
#(
  parameter int unsigned DATA_W = SP_DATA_W,
  parameter int unsigned LANES  = SP_LANES,
  parameter int unsigned KEEP   = SP_KEEP
) (
  input  logic [LANES*DATA_W-1:0]          group_i,
  input  logic [LANES-1:0]                 nz_i,
  output logic [LANES-1:0]                 sel_o,
  output logic [KEEP*DATA_W-1:0]           vals_o,
  output logic [KEEP*$clog2(LANES)-1:0]    idx_o,
  output logic                             viol_o,
  output sp24_class_e                      cls_o
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned MAG_W = DATA_W - 1;
  localparam int unsigned CNT_W = $clog2(LANES + 1);

  function automatic logic [MAG_W-1:0] magnitude(input logic [DATA_W-1:0] w);
    return w[MAG_W-1:0];
  endfunction

  logic [CNT_W-1:0] nz_cnt;
  assign nz_cnt = CNT_W'($countones(nz_i));
  assign cls_o  = classify(int'(nz_cnt), KEEP);
  assign viol_o = (cls_o == CLS_OVER);

  // Rank network: a lane is kept when fewer than KEEP lanes outrank it.
  // Larger magnitude outranks; on equal magnitude the lower lane outranks.
  // Zero lanes have magnitude 0, so padding falls on the lowest zero lanes.
  for (genvar i = 0; i < LANES; i++) begin : g_rank
    logic [LANES-1:0] beaten_by;
    for (genvar j = 0; j < LANES; j++) begin : g_cmp
      if (j == i) begin : g_self
        assign beaten_by[j] = 1'b0;
      end else if (j < i) begin : g_lower
        assign beaten_by[j] =
          magnitude(group_i[j*DATA_W +: DATA_W]) >= magnitude(group_i[i*DATA_W +: DATA_W]);
      end else begin : g_upper
        assign beaten_by[j] =
          magnitude(group_i[j*DATA_W +: DATA_W]) > magnitude(group_i[i*DATA_W +: DATA_W]);
      end
    end
    assign sel_o[i] = ($countones(beaten_by) < KEEP);
  end

  // Compact kept lanes into slots in ascending lane order; zeros canonical.
  always_comb begin
    int slot;
    vals_o = '0;
    idx_o  = '0;
    slot   = 0;
    for (int i = 0; i < LANES; i++) begin
      if (sel_o[i] && slot < KEEP) begin
        vals_o[slot*DATA_W +: DATA_W] = nz_i[i] ? group_i[i*DATA_W +: DATA_W] : '0;
        idx_o[slot*IDX_W +: IDX_W]    = IDX_W'(i);
        slot = slot + 1;
      end
    end
  end
endmodule

// File: rtl/sp24_out_stage.sv
module sp24_out_stage #(
  parameter int unsigned PW = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          vld_q;
  logic [PW-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (in_valid && in_ready) data_q <= in_data;
    end
  end
endmodule

// File: rtl/sp24_expand.sv
module sp24_expand #(
  parameter int unsigned DATA_W = sp24_pkg::SP_DATA_W,
  parameter int unsigned LANES  = sp24_pkg::SP_LANES,
  parameter int unsigned KEEP   = sp24_pkg::SP_KEEP
) (
  input  logic [KEEP*DATA_W-1:0]        vals_i,
  input  logic [KEEP*$clog2(LANES)-1:0] idx_i,
  output logic [LANES*DATA_W-1:0]       group_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      group_o[l*DATA_W +: DATA_W] = '0;
      for (int s = 0; s < KEEP; s++) begin
        if (idx_i[s*IDX_W +: IDX_W] == IDX_W'(l))
          group_o[l*DATA_W +: DATA_W] = vals_i[s*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/sp24_codec.sv
module sp24_codec
  import sp24_pkg::*;
#(
  parameter int unsigned DATA_W = SP_DATA_W,
  parameter int unsigned LANES  = SP_LANES,
  parameter int unsigned KEEP   = SP_KEEP
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*DATA_W-1:0]       in_group,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [KEEP*DATA_W-1:0]        out_vals,
  output logic [KEEP*$clog2(LANES)-1:0] out_idx,
  output logic                          out_viol,
  input  logic [KEEP*DATA_W-1:0]        exp_vals,
  input  logic [KEEP*$clog2(LANES)-1:0] exp_idx,
  output logic [LANES*DATA_W-1:0]       exp_group
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned MAG_W = DATA_W - 1;
  localparam int unsigned PW    = KEEP*DATA_W + KEEP*IDX_W + 1;

  // Named internal events for the checks below.
  logic [LANES-1:0]       lane_nz;
  logic [LANES-1:0]       lane_sel;
  logic [KEEP*DATA_W-1:0] pk_vals;
  logic [KEEP*IDX_W-1:0]  pk_idx;
  logic                   pk_viol;
  sp24_class_e            pk_cls;
  logic [PW-1:0]          st_out;
  logic                   take_in;
  logic                   give_out;

  sp24_zero_detect #(.DATA_W(DATA_W), .LANES(LANES)) u_zero (
    .group_i (in_group),
    .nz_o    (lane_nz)
  );

  sp24_select #(.DATA_W(DATA_W), .LANES(LANES), .KEEP(KEEP)) u_sel (
    .group_i (in_group),
    .nz_i    (lane_nz),
    .sel_o   (lane_sel),
    .vals_o  (pk_vals),
    .idx_o   (pk_idx),
    .viol_o  (pk_viol),
    .cls_o   (pk_cls)
  );

  sp24_out_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({pk_viol, pk_idx, pk_vals}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (st_out)
  );

  assign out_vals = st_out[KEEP*DATA_W-1:0];
  assign out_idx  = st_out[KEEP*DATA_W +: KEEP*IDX_W];
  assign out_viol = st_out[PW-1];

  sp24_expand #(.DATA_W(DATA_W), .LANES(LANES), .KEEP(KEEP)) u_exp (
    .vals_i  (exp_vals),
    .idx_i   (exp_idx),
    .group_o (exp_group)
  );

  assign take_in  = in_valid && in_ready;
  assign give_out = out_valid && out_ready;

  // R1: a stalled output keeps its contents
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vals) && $stable(out_idx) && $stable(out_viol)));

  // R10: an accepted group is presented from the next edge on
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> out_valid);

  // R3: the rank network always keeps exactly KEEP lanes
  p_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_sel) == KEEP);

  // R4: without a violation no non-zero lane is dropped
  p_keep_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_viol |-> ((lane_nz & ~lane_sel) == '0));

  // R7: under a violation only non-zero lanes are kept
  p_over_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pk_viol |-> ((lane_sel & ~lane_nz) == '0));

  for (genvar s = 0; s < KEEP; s++) begin : g_slot_chk
    // R2: emitted zeros carry no sign bit
    p_canon_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_vals[s*DATA_W +: MAG_W] == '0) |-> (out_vals[s*DATA_W +: DATA_W] == '0));
    if (s > 0) begin : g_order
      // R3: slot lane numbers strictly ascending
      p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx[(s-1)*IDX_W +: IDX_W] < out_idx[s*IDX_W +: IDX_W]));
    end
  end

  // R8: a slot value that is non-zero shows up in its named lane
  for (genvar s = 0; s < KEEP; s++) begin : g_exp_chk
    p_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_idx != '0 && exp_vals[s*DATA_W +: DATA_W] != '0 && (s == KEEP-1 ||
        exp_idx[s*IDX_W +: IDX_W] != exp_idx[(KEEP-1)*IDX_W +: IDX_W]))
      |-> (exp_group[exp_idx[s*IDX_W +: IDX_W]*DATA_W +: DATA_W] == exp_vals[s*DATA_W +: DATA_W]));
  end

  logic unused_evt;
  assign unused_evt = give_out ^ (pk_cls == CLS_EMPTY);
endmodule

// File: tb/sp24_codec_tb.sv
module sp24_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_group = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_vals;
  logic [3:0]  out_idx;
  logic        out_viol;
  logic [31:0] exp_vals = '0;
  logic [3:0]  exp_idx = 4'b0100;
  logic [63:0] exp_group;

  always #4 clk = ~clk;

  sp24_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_group(in_group),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vals(out_vals), .out_idx(out_idx), .out_viol(out_viol),
    .exp_vals(exp_vals), .exp_idx(exp_idx), .exp_group(exp_group)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_vals[$];
  logic [3:0]  q_idx[$];
  logic        q_viol[$];
  logic [63:0] q_orig[$];
  logic        q_exact[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Behavioural model of the packing rules.
  function automatic void model(input logic [63:0] g, output logic [31:0] v,
                                output logic [3:0] ix, output logic viol,
                                output logic exact, output string tag);
    int cnt, need, s, best;
    int m[4];
    bit pick[4];
    cnt = 0;
    exact = 1'b1;
    for (int l = 0; l < 4; l++) begin
      m[l] = int'(g[l*16 +: 15]);
      pick[l] = 0;
      if (m[l] != 0) cnt++;
      else if (g[l*16 +: 16] != 16'h0) exact = 1'b0;
    end
    viol = (cnt > 2);
    if (viol) exact = 1'b0;
    tag = (cnt == 0) ? "R6" : (cnt == 1) ? "R5" : (cnt == 2) ? "R4" : "R7";
    if (cnt <= 2) begin
      for (int l = 0; l < 4; l++) if (m[l] != 0) pick[l] = 1;
      need = 2 - cnt;
      for (int l = 0; l < 4; l++)
        if (need > 0 && m[l] == 0) begin pick[l] = 1; need--; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        best = -1;
        for (int l = 0; l < 4; l++)
          if (!pick[l] && (best < 0 || m[l] > m[best])) best = l;
        pick[best] = 1;
      end
    end
    v = '0; ix = '0; s = 0;
    for (int l = 0; l < 4; l++) if (pick[l]) begin
      v[s*16 +: 16] = (m[l] != 0) ? g[l*16 +: 16] : 16'h0;
      ix[s*2 +: 2]  = 2'(l);
      s++;
    end
  endfunction

  function automatic logic [63:0] unpack(input logic [31:0] v, input logic [3:0] ix);
    logic [63:0] r;
    r = '0;
    for (int s = 0; s < 2; s++) r[ix[s*2 +: 2]*16 +: 16] = v[s*16 +: 16];
    return r;
  endfunction

  // One cycle: check at the negedge, drive, then book the transfers.
  task automatic step(input bit v, input logic [63:0] g, input bit rdy, output bit taken);
    logic [31:0] mv; logic [3:0] mi; logic mviol, mex; string mtag;
    @(negedge clk);
    chk(out_valid == (q_vals.size() > 0), "R10 out_valid", 64'(out_valid), 64'(q_vals.size() > 0));
    if (out_valid && q_vals.size() > 0) begin
      chk(out_vals == q_vals[0], {q_tag[0], " values"}, 64'(out_vals), 64'(q_vals[0]));
      chk(out_idx == q_idx[0], {q_tag[0], " lanes"}, 64'(out_idx), 64'(q_idx[0]));
      chk(out_viol == q_viol[0], {q_tag[0], " flag"}, 64'(out_viol), 64'(q_viol[0]));
      chk(out_idx[1:0] < out_idx[3:2], "R3 order", 64'(out_idx), 64'(q_idx[0]));
      for (int s = 0; s < 2; s++)
        if (out_vals[s*16 +: 15] == '0)
          chk(out_vals[s*16 +: 16] == 16'h0, "R2 canonical zero", 64'(out_vals[s*16 +: 16]), 64'h0);
      exp_vals = out_vals;
      exp_idx  = out_idx;
      #1;
      chk(exp_group == unpack(out_vals, out_idx), "R8 unpack", exp_group, unpack(out_vals, out_idx));
      if (q_exact[0]) chk(exp_group == q_orig[0], "R8 round trip", exp_group, q_orig[0]);
    end
    in_valid  = v;
    in_group  = g;
    out_ready = rdy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R1 ready", 64'(in_ready), 64'(!out_valid || out_ready));
    taken = in_valid && in_ready;
    if (out_valid && out_ready) begin
      void'(q_vals.pop_front()); void'(q_idx.pop_front()); void'(q_viol.pop_front());
      void'(q_orig.pop_front()); void'(q_exact.pop_front()); void'(q_tag.pop_front());
    end
    if (taken) begin
      model(g, mv, mi, mviol, mex, mtag);
      q_vals.push_back(mv); q_idx.push_back(mi); q_viol.push_back(mviol);
      q_orig.push_back(g); q_exact.push_back(mex); q_tag.push_back(mtag);
    end
  endtask

  function automatic logic [15:0] rand_lane();
    logic [15:0] w;
    case ($urandom % 5)
      0: w = 16'h0000;
      1: w = 16'h8000;
      2: begin
        case ($urandom % 4)
          0: w = 16'h3C00; 1: w = 16'hBC00; 2: w = 16'h4000; default: w = 16'h3800;
        endcase
      end
      3: w = 16'h0000;
      default: begin
        w = 16'($urandom);
        if (w[14:0] == '0) w[0] = 1'b1;
      end
    endcase
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] dir[10];
    logic [63:0] g;
    bit tk, hold;
    dir[0] = {16'h0000, 16'h34CD, 16'h0000, 16'h3800}; // two kept, lanes 0 and 2
    dir[1] = {16'h3266, 16'h0000, 16'h399A, 16'h0000}; // two kept, lanes 1 and 3
    dir[2] = 64'h0;                                     // empty
    dir[3] = {16'h8000, 16'h0000, 16'h8000, 16'h0000}; // negative zeros only
    dir[4] = {16'h0000, 16'h0000, 16'h0000, 16'hC200}; // single in lane 0
    dir[5] = {16'h4500, 16'h8000, 16'h0000, 16'h0000}; // single in lane 3
    dir[6] = {16'h3C00, 16'hB800, 16'h0000, 16'h4000}; // three non-zero
    dir[7] = {16'h3C00, 16'h3C00, 16'hBC00, 16'h3C00}; // four with equal magnitude
    dir[8] = {16'h3800, 16'hC400, 16'h3C00, 16'h3400}; // negative is largest
    dir[9] = {16'h0001, 16'h0000, 16'h8001, 16'h0000}; // subnormals, two kept

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 64'h1);
    rst_n = 1'b1;

    // Back-to-back with the consumer always ready: drain and refill coincide.
    for (int i = 0; i < 10; i++) step(1'b1, dir[i], 1'b1, tk);
    step(1'b0, '0, 1'b1, tk);
    step(1'b0, '0, 1'b1, tk);

    // Stall with a full register, then release.
    step(1'b1, dir[6], 1'b0, tk);
    step(1'b1, dir[7], 1'b0, tk);
    step(1'b1, dir[7], 1'b0, tk);
    step(1'b1, dir[7], 1'b1, tk);
    step(1'b0, '0, 1'b1, tk);
    step(1'b0, '0, 1'b1, tk);

    // Random traffic with random backpressure; an offered group is held until taken.
    hold = 0; g = '0;
    for (int n = 0; n < 3000; n++) begin
      if (!hold) g = {rand_lane(), rand_lane(), rand_lane(), rand_lane()};
      if (hold || ($urandom % 4 != 0)) begin
        step(1'b1, g, ($urandom % 3 != 0), tk);
        hold = !tk;
      end else begin
        step(1'b0, '0, ($urandom % 3 != 0), tk);
      end
    end
    for (int n = 0; n < 4; n++) step(1'b0, '0, 1'b1, tk);
    chk(q_vals.size() == 0, "R10 drained", 64'(q_vals.size()), 64'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule